// File: doc/BRIEF.md
# Two-Channel Single- and Dual-Slope PWM Generator

This block turns a shared tick enable into two pulse-width modulated outputs. An 8-bit counter advances once per tick, either as a sawtooth (up to TOP, then back to zero) or as a triangle (up to TOP, then down to zero). The top of the count is either the full-scale value or the active compare value of channel A. Each channel compares its own active compare value against the count and drives its pin according to a 2-bit output code.

Compare values are written through a single shared data bus with one write strobe per channel. A write first lands in a holding buffer. The buffer is copied into the active compare register only on the tick that brings the counter to zero, so a running cycle is never cut short or stretched. In the dual-slope variant with buffered TOP, the choice of TOP source is also held until zero. The block reports a one-clock pulse whenever the counter reaches zero, and it reports the current count direction.

The clock prescaler and non-PWM counting modes are not part of this block.

Top module: `pwm2_gen`

## Requirements
- R1: While `rst_n` is low and right after it rises, `pwm_a`, `pwm_b`, `bottom_pulse` and `count_down` are 0, and the count starts at 0 moving up.
- R2: In single-slope mode (`wave_mode` 00, and 11 which behaves the same), each tick moves the count from 0 up to TOP and then back to 0, so one period lasts TOP+1 ticks. TOP is 255 when `top_from_cmpa` is 0, and the active compare A value when it is 1.
- R3: In single-slope mode with output code 10, the pin is high while the count is at or below the channel's active compare value and low above it. Code 11 gives the complement. With TOP 255, compare 127 gives 128 high ticks out of 256, and compare 0 gives a single high tick.
- R4: Output codes 00 and 01 disconnect a channel, and its pin is then driven low.
- R5: In dual-slope modes (`wave_mode` 01 and 10), the count rises from 0 to TOP and falls back to 0, so one period lasts 2·TOP ticks. `count_down` goes to 1 on the tick that reaches TOP and back to 0 on the tick that reaches 0. It is 0 in single-slope mode.
- R6: In dual-slope modes with code 10, the pin is cleared when the count moves up past the compare value and set when the count moves down onto it, so the pin is high exactly while the count is at or below compare. Code 11 gives the complement.
- R7: A compare write goes to a holding buffer. The active value takes the buffered value only on the tick that brings the count to 0. A write on that same clock waits for the next such tick.
- R8: `bottom_pulse` is high for exactly the clock that follows each tick that brings the count to 0, and it is low at all other times.
- R9: While `tick` is low, the count, the direction and both pins hold their values, and no bottom pulse occurs.
- R10: While compare A is the effective TOP source, `pwm_a` is low whatever its output code.
- R11: In `wave_mode` 00 and 01, a change of `top_from_cmpa` applies from the next tick. In `wave_mode` 10, the TOP source is sampled only on the tick that reaches 0, so every period is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one step per high clock |
| wave_mode | input | 2 | 00 single-slope, 01 dual-slope, 10 dual-slope with TOP held until zero, 11 as 00 |
| top_from_cmpa | input | 1 | 1 selects active compare A as TOP, 0 selects 255 |
| oc_mode_a | input | 2 | Channel A output code: 0x off, 10 non-inverting, 11 inverting |
| oc_mode_b | input | 2 | Channel B output code, same encoding |
| cmp_wr_a | input | 1 | Write strobe for the compare A buffer |
| cmp_wr_b | input | 1 | Write strobe for the compare B buffer |
| cmp_wdata | input | W | Compare write data shared by both strobes |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| bottom_pulse | output | 1 | One-clock pulse after the count reaches 0 |
| count_down | output | 1 | 1 while the count is on its falling slope |

## Verification
The step properties take for granted that `tick` and `wave_mode` are steady around each rising edge, so the step taken matches the mode seen at that edge. The stimulus therefore changes every input only on the falling edge. The waveform level rule (pin follows count against compare) is only meaningful once a zero has been passed with the current output code. For that reason the stimulus changes output codes and mode at known points and resumes pin checks after the next bottom. The stimulus also moves the TOP selection only while the count is below the new TOP, so the counter never has to recover from sitting above its limit.

// File: rtl/pwm2_pkg.sv
// Shared definitions for the two-channel PWM generator.
// Assumes: channel 0 is A (may serve as TOP source), channel 1 is B.
package pwm2_pkg;
    localparam int NCH = 2;

    typedef enum logic [1:0] {
        WM_SINGLE   = 2'b00,
        WM_DUAL     = 2'b01,
        WM_DUAL_HLD = 2'b10,
        WM_SINGLE2  = 2'b11
    } wave_mode_e;

    // Output code that makes the pin high in the low part of the count.
    localparam logic [1:0] OC_NONINV = 2'b10;

    function automatic logic is_dual(input wave_mode_e m);
        return (m == WM_DUAL) || (m == WM_DUAL_HLD);
    endfunction
endpackage

// File: rtl/pwm2_counter.sv
// Timebase for the PWM generator: single- or dual-slope counter with a
// selectable TOP and an optionally bottom-latched TOP source.
// Assumes: tick is a clock enable; cmpa_act is the active compare A.
module pwm2_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dual,
    input  logic         hold_top,
    input  logic         top_sel_in,
    input  logic [W-1:0] cmpa_act,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         step_up,
    output logic         load_evt,
    output logic         down,
    output logic         bottom_flag,
    output logic         top_sel_eff
);
    localparam logic [W-1:0] MAXV = '1;

    logic         top_sel_q;
    logic         down_nxt;
    logic [W-1:0] top_val;

    assign top_sel_eff = hold_top ? top_sel_q : top_sel_in;
    assign top_val     = top_sel_eff ? cmpa_act : MAXV;
    assign load_evt    = tick && (cnt_nxt == '0);

    // Next count and direction for one tick.
    always_comb begin
        if (!dual) begin
            step_up = 1'b1;
            cnt_nxt = (cnt >= top_val) ? '0 : cnt + 1'b1;
        end else if (!down && (cnt < top_val)) begin
            step_up = 1'b1;
            cnt_nxt = cnt + 1'b1;
        end else begin
            step_up = 1'b0;
            cnt_nxt = (cnt == '0) ? '0 : cnt - 1'b1;
        end
        if (!dual || (cnt_nxt == '0))
            down_nxt = 1'b0;
        else if (cnt_nxt >= top_val)
            down_nxt = 1'b1;
        else
            down_nxt = down;
    end

    // Count and direction registers, advanced on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (tick) begin
            cnt  <= cnt_nxt;
            down <= down_nxt;
        end
    end

    // Bottom pulse and bottom-sampled TOP source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bottom_flag <= 1'b0;
            top_sel_q   <= 1'b0;
        end else begin
            bottom_flag <= load_evt;
            if (load_evt)
                top_sel_q <= top_sel_in;
        end
    end
endmodule

// File: rtl/pwm2_cmp_buf.sv
// Double-buffered compare register: writes fill a holding buffer that is
// copied to the active value on the load event (count reaching zero).
// Assumes: load is a single-clock event from the counter.
module pwm2_cmp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] act
);
    logic [W-1:0] hold_q;

    // Holding buffer, written by software-side strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  hold_q <= '0;
        else if (wr) hold_q <= wdata;
    end

    // Active value, refreshed only at bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)    act <= '0;
        else if (load) act <= hold_q;
    end
endmodule

// File: rtl/pwm2_out_unit.sv
// One PWM output channel: sets its pin to the base level at bottom, flips
// it when the count leaves the compare value upward and restores it when
// the count arrives at the compare value downward.
// Assumes: cnt/cnt_nxt/step_up/load_evt come from pwm2_counter.
module pwm2_out_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         step_up,
    input  logic         load_evt,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_nxt,
    input  logic [1:0]   code,
    input  logic [W-1:0] cmp,
    input  logic         force_off,
    output logic         pin
);
    logic pin_q;
    logic base;

    assign base = (code == pwm2_pkg::OC_NONINV);
    assign pin  = (code[1] && !force_off) ? pin_q : 1'b0;

    // Pin state machine driven by bottom and compare events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else if (load_evt)
            pin_q <= base;
        else if (tick && step_up && (cnt == cmp))
            pin_q <= !base;
        else if (tick && !step_up && (cnt_nxt == cmp))
            pin_q <= base;
    end
endmodule

// File: rtl/pwm2_gen.sv
// Two-channel PWM generator top: one shared counter, two double-buffered
// compare registers and two output units. Channel A's compare may serve as
// TOP, in which case its pin is forced low.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module pwm2_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   wave_mode,
    input  logic         top_from_cmpa,
    input  logic [1:0]   oc_mode_a,
    input  logic [1:0]   oc_mode_b,
    input  logic         cmp_wr_a,
    input  logic         cmp_wr_b,
    input  logic [W-1:0] cmp_wdata,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic         bottom_pulse,
    output logic         count_down
);
    import pwm2_pkg::*;

    wave_mode_e            mode;
    logic [W-1:0]          cnt_w;
    logic [W-1:0]          cnt_nxt_w;
    logic                  step_up_w;
    logic                  load_w;
    logic                  down_w;
    logic                  top_sel_w;
    logic [W-1:0]          act_v [NCH];
    logic [1:0]            code_v [NCH];
    logic [NCH-1:0]        wr_v;
    logic [NCH-1:0]        off_v;
    logic [NCH-1:0]        pin_v;
    logic [W-1:0]          cmp_act_b;

    assign mode      = wave_mode_e'(wave_mode);
    assign code_v[0] = oc_mode_a;
    assign code_v[1] = oc_mode_b;
    assign wr_v      = {cmp_wr_b, cmp_wr_a};
    assign off_v     = {1'b0, top_sel_w};
    assign pwm_a     = pin_v[0];
    assign pwm_b     = pin_v[1];
    assign count_down = down_w;
    assign cmp_act_b = act_v[1];

    pwm2_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .dual       (is_dual(mode)),
        .hold_top   (mode == WM_DUAL_HLD),
        .top_sel_in (top_from_cmpa),
        .cmpa_act   (act_v[0]),
        .cnt        (cnt_w),
        .cnt_nxt    (cnt_nxt_w),
        .step_up    (step_up_w),
        .load_evt   (load_w),
        .down       (down_w),
        .bottom_flag(bottom_pulse),
        .top_sel_eff(top_sel_w)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwm2_cmp_buf #(.W(W)) u_buf (
            .clk  (clk),
            .rst_n(rst_n),
            .wr   (wr_v[ch]),
            .wdata(cmp_wdata),
            .load (load_w),
            .act  (act_v[ch])
        );
        pwm2_out_unit #(.W(W)) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .step_up  (step_up_w),
            .load_evt (load_w),
            .cnt      (cnt_w),
            .cnt_nxt  (cnt_nxt_w),
            .code     (code_v[ch]),
            .cmp      (act_v[ch]),
            .force_off(off_v[ch]),
            .pin      (pin_v[ch])
        );
    end
endmodule

// File: rtl/pwm2_gen_chk.sv
// Property checker for pwm2_gen, attached by bind. Observes the counter,
// the channel B active compare and the ports.
module pwm2_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [1:0]   wave_mode,
    input logic [W-1:0] cnt,
    input logic         down,
    input logic         bottom_flag,
    input logic [W-1:0] cmp_act_b,
    input logic         top_sel_eff,
    input logic         pwm_a
);
    logic is_single;
    assign is_single = (wave_mode == 2'b00) || (wave_mode == 2'b11);

    // R9: no tick, no movement and no bottom pulse
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && !bottom_flag));

    // R8: the bottom pulse coincides with a zero count
    assert_bottom_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bottom_flag |-> (cnt == '0));

    // R2: single-slope steps by one or wraps to zero
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && is_single) |=> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

    // R5: on the falling slope each tick decrements
    assert_dual_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !is_single && down) |=> (cnt == $past(cnt) - 1'b1));

    // R7: the active compare changes only when the count lands on zero
    assert_cmp_at_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_act_b) |-> (cnt == '0));

    // R10: channel A stays low while it is the TOP source
    assert_chan_a_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        top_sel_eff |-> !pwm_a);
endmodule

bind pwm2_gen pwm2_gen_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wave_mode  (wave_mode),
    .cnt        (cnt_w),
    .down       (down_w),
    .bottom_flag(bottom_pulse),
    .cmp_act_b  (cmp_act_b),
    .top_sel_eff(top_sel_w),
    .pwm_a      (pwm_a)
);

// File: tb/test_pwm2_gen.sv
`timescale 1ns/1ps
// Directed bench for pwm2_gen with a cycle-level reference model.
module test_pwm2_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       topsel_i = 1'b0;
    logic [1:0] oca_i = 2'b00;
    logic [1:0] ocb_i = 2'b00;
    logic       wra_i = 1'b0;
    logic       wrb_i = 1'b0;
    logic [7:0] wdata_i = 8'd0;
    logic       pwm_a, pwm_b, bottom_pulse, count_down;

    always #2 clk = ~clk;

    pwm2_gen #(.W(8)) i_pwm2_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .wave_mode(mode_i),
        .top_from_cmpa(topsel_i), .oc_mode_a(oca_i), .oc_mode_b(ocb_i),
        .cmp_wr_a(wra_i), .cmp_wr_b(wrb_i), .cmp_wdata(wdata_i),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .bottom_pulse(bottom_pulse),
        .count_down(count_down)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    // reference model state
    int m_cnt = 0, m_down = 0, m_cmp_a = 0, m_cmp_b = 0, p_cmp_a = 0, p_cmp_b = 0;
    bit m_topq = 0, m_sync = 0, m_ev = 0, tick_alt = 0;
    bit w_a_v = 0, w_b_v = 0;
    int w_d = 0;
    int hi_a = 0, hi_b = 0, n_bot = 0, n_dn = 0;
    string cur_tag = "R3";

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lev(input logic [1:0] code, input int cmp, input bit off);
        bit base;
        base = (code == 2'b10);
        if (!code[1] || off) return 0;
        return (m_cnt <= cmp) ? int'(base) : int'(!base);
    endfunction

    // One clock: advance the model at the edge, compare at the falling edge.
    task automatic step1();
        int  t, nc;
        bit  eff, dual;
        @(posedge clk);
        dual = (mode_i == 2'b01) || (mode_i == 2'b10);
        eff  = (mode_i == 2'b10) ? m_topq : topsel_i;
        t    = eff ? m_cmp_a : 255;
        m_ev = 0;
        if (tick_i) begin
            if (!dual) nc = (m_cnt >= t) ? 0 : m_cnt + 1;
            else if (!m_down && m_cnt < t) nc = m_cnt + 1;
            else nc = (m_cnt == 0) ? 0 : m_cnt - 1;
            if (!dual || nc == 0) m_down = 0;
            else if (nc >= t) m_down = 1;
            m_cnt = nc;
            if (nc == 0) begin
                m_ev = 1; m_cmp_a = p_cmp_a; m_cmp_b = p_cmp_b;
                m_topq = topsel_i; m_sync = 1;
            end
        end
        if (w_a_v) p_cmp_a = w_d;
        if (w_b_v) p_cmp_b = w_d;
        eff = (mode_i == 2'b10) ? m_topq : topsel_i;
        @(negedge clk);
        chk("R8 bottom_pulse", int'(bottom_pulse), int'(m_ev));
        chk("R5 count_down", int'(count_down), m_down);
        if (m_sync) begin
            chk({cur_tag, " pwm_a"}, int'(pwm_a), lev(oca_i, m_cmp_a, eff));
            chk({cur_tag, " pwm_b"}, int'(pwm_b), lev(ocb_i, m_cmp_b, 1'b0));
        end
        hi_a += int'(pwm_a); hi_b += int'(pwm_b);
        n_bot += int'(m_ev); n_dn += m_down;
        wra_i = 0; wrb_i = 0; w_a_v = 0; w_b_v = 0;
        if (tick_alt) tick_i = ~tick_i;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step1();
    endtask

    task automatic run_to_bottom(output int n);
        n = 0;
        do begin step1(); n++; end while (!m_ev && n < 3000);
        if (!m_ev) chk("R8 bottom reached", 0, 1);
    endtask

    task automatic clr();
        hi_a = 0; hi_b = 0; n_bot = 0; n_dn = 0;
    endtask

    task automatic cfg(input logic [1:0] md, input logic ts, input logic [1:0] ca, input logic [1:0] cb);
        mode_i = md; topsel_i = ts; oca_i = ca; ocb_i = cb; m_sync = 0;
    endtask

    task automatic wr_a(input int v);
        wra_i = 1; wdata_i = 8'(v); w_a_v = 1; w_d = v; step1();
    endtask

    task automatic wr_b(input int v);
        wrb_i = 1; wdata_i = 8'(v); w_b_v = 1; w_d = v; step1();
    endtask

    // R1: reset values
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 pwm_a in reset", int'(pwm_a), 0);
        chk("R1 pwm_b in reset", int'(pwm_b), 0);
        chk("R1 bottom_pulse in reset", int'(bottom_pulse), 0);
        chk("R1 count_down in reset", int'(count_down), 0);
        rst_n = 1; tick_i = 1;
        step1();
        chk("R1 first step no bottom", int'(bottom_pulse), 0);
    endtask

    // R2, R3: single-slope duty and period with full-scale TOP
    task automatic t_single();
        int n;
        cur_tag = "R3 single";
        cfg(2'b00, 0, 2'b11, 2'b10);
        wr_a(0); wr_b(127);
        run_to_bottom(n); run_to_bottom(n);
        clr(); steps(256);
        chk("R2 one bottom per 256 ticks", n_bot, 1);
        chk("R3 compare 127 high ticks", hi_b, 128);
        chk("R3 inverted compare 0 high ticks", hi_a, 255);
        cfg(2'b00, 0, 2'b10, 2'b10);
        run_to_bottom(n); clr(); steps(256);
        chk("R3 compare 0 single high tick", hi_a, 1);
        chk("R2 period 256", n, 256);
    endtask

    // R4: disconnected codes
    task automatic t_off();
        int n;
        cur_tag = "R4 off";
        cfg(2'b00, 0, 2'b00, 2'b01);
        run_to_bottom(n); clr(); steps(300);
        chk("R4 code 00 pin low", hi_a, 0);
        chk("R4 code 01 pin low", hi_b, 0);
    endtask

    // R5, R6: dual-slope waveform and direction
    task automatic t_dual();
        int n;
        cur_tag = "R6 dual";
        cfg(2'b01, 0, 2'b11, 2'b10);
        wr_a(200); wr_b(63);
        run_to_bottom(n); run_to_bottom(n);
        clr(); run_to_bottom(n);
        chk("R5 dual period 510", n, 510);
        chk("R5 falling-slope ticks", n_dn, 255);
        chk("R6 code 10 compare 63 high ticks", hi_b, 127);
        chk("R6 code 11 compare 200 high ticks", hi_a, 109);
    endtask

    // R7: compare write mid-cycle waits for bottom
    task automatic t_buffer();
        int n;
        cur_tag = "R7 buffered";
        cfg(2'b00, 0, 2'b00, 2'b10);
        wr_b(200);
        run_to_bottom(n); run_to_bottom(n);
        clr(); steps(50); wr_b(20); run_to_bottom(n);
        chk("R7 old compare kept to bottom", hi_b, 201);
        clr(); run_to_bottom(n);
        chk("R7 new compare after bottom", hi_b, 21);
    endtask

    // R10, R2: compare A as TOP
    task automatic t_top_a();
        int n;
        cur_tag = "R10 top a";
        cfg(2'b00, 0, 2'b10, 2'b10);
        wr_a(99); wr_b(49);
        run_to_bottom(n); run_to_bottom(n);
        topsel_i = 1;
        clr(); run_to_bottom(n);
        chk("R2 period with compare A TOP", n, 100);
        chk("R10 pwm_a held low", hi_a, 0);
        chk("R3 compare 49 over TOP 99", hi_b, 50);
    endtask

    // R9: tick gating
    task automatic t_tick();
        int n;
        logic pb;
        cur_tag = "R9 tick";
        cfg(2'b00, 0, 2'b00, 2'b10);
        run_to_bottom(n); tick_alt = 1;
        run_to_bottom(n);
        run_to_bottom(n);
        chk("R9 half-rate period", n, 512);
        tick_alt = 0; tick_i = 0;
        steps(5); pb = pwm_b; clr(); steps(30);
        chk("R9 no bottom while idle", n_bot, 0);
        chk("R9 pwm_b held", int'(pwm_b), int'(pb));
        tick_i = 1;
    endtask

    // R11: TOP selection timing per mode
    task automatic t_top_timing();
        int n;
        cur_tag = "R11 top timing";
        cfg(2'b01, 0, 2'b00, 2'b10);
        wr_a(20);
        run_to_bottom(n); run_to_bottom(n);
        steps(5); topsel_i = 1;
        run_to_bottom(n);
        chk("R11 immediate TOP in mode 01", n, 35);
        mode_i = 2'b10; topsel_i = 0;
        run_to_bottom(n);
        chk("R11 latched TOP holds previous source", n, 40);
        steps(5); topsel_i = 1;
        run_to_bottom(n);
        chk("R11 mode 10 keeps TOP 255 until bottom", n, 505);
        run_to_bottom(n);
        chk("R11 mode 10 new TOP after bottom", n, 40);
    endtask

    initial begin
        t_reset();
        t_single();
        t_off();
        t_dual();
        t_buffer();
        t_top_a();
        t_tick();
        t_top_timing();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule